// File: doc/BRIEF.md
# DSI Command Packet Formatter

This block turns one host command into the 32-bit words that a display serial transmit path expects. A request names a data type, a virtual channel and a byte count. The bytes of the command then arrive one per handshake on a separate byte port. The block decides whether the command is a short or a long packet and drops any request it cannot encode, raising an error pulse. For a valid request it emits the payload words first and the header word last, each through a valid/ready output that carries a tag telling payload from header.

When the requester sets the automatic command-set flag, the block ignores the supplied data type. It chooses the write code from the byte count instead. A byte count above the configured transmit buffer capacity raises a warning pulse, and the packet is still sent. Error-correction bytes, checksums, lane splitting and the physical layer are handled by other blocks.

Top module: `dsi_pkt_fmt`

## Requirements
- R1: The header identifier byte (bits 7:0 of the header word) holds the data type in bits 5:0 and the virtual channel in bits 7:6. Bits 31:24 of the header word are zero.
- R2: A packet is short when bits 3:0 of its data type are below 9 and long otherwise. A short packet sends only the header word. A long packet sends ceil(count/4) payload words and then the header.
- R3: A request with a byte count of zero, or a short request with more than two bytes, raises `err_reject` for one cycle in the cycle after acceptance. Such a request takes no bytes and produces no output, and `req_ready` stays high.
- R4: For a short packet, header bits 15:8 carry the first byte. Header bits 23:16 carry the second byte, or zero when the count is one.
- R5: For a long packet, header bits 15:8 carry the low byte of the count and header bits 23:16 carry the high byte.
- R6: Payload bytes are packed four per word with the earliest byte in bits 7:0. Unused upper bytes of a final partial word are zero.
- R7: Every payload word has `out_is_hdr` low. The header word has `out_is_hdr` high and is always the last word of its packet. No bytes are accepted while a word is offered.
- R8: With `req_auto_dcs` high, the supplied data type is ignored. A count of 1 selects 0x05, a count of 2 selects 0x15, and a count of 3 or more selects 0x39.
- R9: A count above `FIFO_BYTES` raises `warn_oversize` for one cycle in the cycle after acceptance. The whole packet is still emitted. A count equal to `FIFO_BYTES` raises no warning.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_is_hdr` hold. `req_ready` stays low from acceptance until the header word has been taken.
- R11: After reset, `req_ready` is high and `out_valid`, `byte_ready`, `err_reject` and `warn_oversize` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Formatter idle, request taken |
| req_dtype | input | 6 | Packet data type |
| req_vc | input | 2 | Virtual channel |
| req_len | input | LEN_W | Command byte count |
| req_auto_dcs | input | 1 | Pick write code from the count |
| byte_valid | input | 1 | Command byte offered |
| byte_ready | output | 1 | Command byte taken |
| byte_data | input | 8 | Command byte |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output word taken |
| out_data | output | 32 | Payload or header word |
| out_is_hdr | output | 1 | Word is the header |
| err_reject | output | 1 | Request dropped pulse |
| warn_oversize | output | 1 | Count above buffer capacity pulse |

## Verification
The checker relies on two things about the requester. First, after an accepted request it supplies exactly the announced number of bytes. Second, it expects no new request to be taken while a packet is in flight. The bench meets both: each packet's byte task drives exactly the count it requested, and it offers a new request only after `req_ready` has returned. The output side may stall at any time. The bench holds `out_ready` low in one directed case to exercise the hold rules, and it never otherwise needs a well-behaved sink.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_PAY  = 2'd2,
      ST_HDR  = 2'd3
   } fmt_state_t;

   localparam logic [5:0] DT_CMD_WR0  = 6'h05;
   localparam logic [5:0] DT_CMD_WR1  = 6'h15;
   localparam logic [5:0] DT_CMD_LONG = 6'h39;
   localparam logic [3:0] SHORT_LIMIT = 4'd9;
   localparam int         WORD_BYTES  = 4;
endpackage

// File: rtl/dsi_pkt_classify.sv
module dsi_pkt_classify
   import dsi_pkt_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int FIFO_BYTES = 64,
   parameter bit AUTO_DCS   = 1'b1
) (
   input  logic [5:0]       dtype,
   input  logic             auto_dcs,
   input  logic [LEN_W-1:0] len,
   output logic [5:0]       dt_eff,
   output logic             is_short,
   output logic             reject,
   output logic             oversize
);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(FIFO_BYTES);

   generate
      if (AUTO_DCS) begin : g_auto
         always_comb begin
            if (!auto_dcs)                dt_eff = dtype;
            else if (len == LEN_W'(1))    dt_eff = DT_CMD_WR0;
            else if (len == LEN_W'(2))    dt_eff = DT_CMD_WR1;
            else                          dt_eff = DT_CMD_LONG;
         end
      end else begin : g_fixed
         logic unused_auto;
         assign unused_auto = auto_dcs;
         assign dt_eff      = dtype;
      end
   endgenerate

   assign is_short = dt_eff[3:0] < SHORT_LIMIT;
   assign reject   = (len == '0) || (is_short && (len > LEN_W'(2)));
   assign oversize = len > CAP;
endmodule

// File: rtl/dsi_pkt_packer.sv
module dsi_pkt_packer
   import dsi_pkt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        push,
   input  logic [7:0]  din,
   output logic [31:0] word,
   output logic        full_next
);
   logic [1:0] lane_q;

   assign full_next = push && (lane_q == 2'(WORD_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word   <= '0;
         lane_q <= '0;
      end else if (clr) begin
         word   <= '0;
         lane_q <= '0;
      end else if (push) begin
         word[lane_q*8 +: 8] <= din;
         lane_q              <= lane_q + 2'd1;
      end
   end
endmodule

// File: rtl/dsi_pkt_fmt.sv
module dsi_pkt_fmt
   import dsi_pkt_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int FIFO_BYTES = 64,
   parameter bit AUTO_DCS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [5:0]       req_dtype,
   input  logic [1:0]       req_vc,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_auto_dcs,
   input  logic             byte_valid,
   output logic             byte_ready,
   input  logic [7:0]       byte_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [31:0]      out_data,
   output logic             out_is_hdr,
   output logic             err_reject,
   output logic             warn_oversize
);
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("dsi_pkt_fmt: LEN_W must lie in 2..16");
   end
   if (FIFO_BYTES < 1 || FIFO_BYTES >= (1 << LEN_W)) begin : g_bad_cap
      $error("dsi_pkt_fmt: FIFO_BYTES must fit in LEN_W bits");
   end

   fmt_state_t       state_q;
   logic [7:0]       id_q;
   logic             short_q;
   logic [LEN_W-1:0] len_q, rem_q;
   logic             err_q, warn_q;

   logic [5:0]  dt_eff;
   logic        is_short, reject, oversize;
   logic        take_req, take_byte, last_byte, pk_clr, full_next;
   logic [31:0] word;
   logic [15:0] len16;

   dsi_pkt_classify #(
      .LEN_W(LEN_W), .FIFO_BYTES(FIFO_BYTES), .AUTO_DCS(AUTO_DCS)
   ) u_cls (
      .dtype(req_dtype), .auto_dcs(req_auto_dcs), .len(req_len),
      .dt_eff(dt_eff), .is_short(is_short), .reject(reject),
      .oversize(oversize)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign byte_ready = (state_q == ST_FILL);
   assign out_valid  = (state_q == ST_PAY) || (state_q == ST_HDR);
   assign out_is_hdr = (state_q == ST_HDR);

   assign take_req  = req_valid && req_ready;
   assign take_byte = byte_valid && byte_ready;
   assign last_byte = take_byte && (rem_q == LEN_W'(1));
   assign pk_clr    = (take_req && !reject) ||
                      ((state_q == ST_PAY) && out_ready && (rem_q != '0));

   dsi_pkt_packer u_pack (
      .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(take_byte),
      .din(byte_data), .word(word), .full_next(full_next)
   );

   assign len16 = 16'(len_q);

   always_comb begin
      if (state_q == ST_HDR) begin
         if (short_q) out_data = {8'h00, word[15:8], word[7:0], id_q};
         else         out_data = {8'h00, len16[15:8], len16[7:0], id_q};
      end else begin
         out_data = word;
      end
   end

   assign err_reject    = err_q;
   assign warn_oversize = warn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         id_q    <= '0;
         short_q <= 1'b0;
         len_q   <= '0;
         rem_q   <= '0;
         err_q   <= 1'b0;
         warn_q  <= 1'b0;
      end else begin
         err_q  <= 1'b0;
         warn_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (take_req) begin
               if (reject) begin
                  err_q <= 1'b1;
               end else begin
                  id_q    <= {req_vc, dt_eff};
                  short_q <= is_short;
                  len_q   <= req_len;
                  rem_q   <= req_len;
                  warn_q  <= oversize;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: if (take_byte) begin
               rem_q <= rem_q - LEN_W'(1);
               if (last_byte)                  state_q <= short_q ? ST_HDR : ST_PAY;
               else if (full_next && !short_q) state_q <= ST_PAY;
            end
            ST_PAY: if (out_ready) begin
               state_q <= (rem_q == '0) ? ST_HDR : ST_FILL;
            end
            ST_HDR: if (out_ready) begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dsi_pkt_fmt_chk.sv
module dsi_pkt_fmt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        byte_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_data,
   input logic        out_is_hdr,
   input logic        err_reject
);
   a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_hdr));

   a_r10_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready);

   a_r7_header_last: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_is_hdr |=> !out_valid && req_ready);

   a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_reject |-> req_ready && !out_valid);

   a_r7_fill_vs_send: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |-> !out_valid);
endmodule

bind dsi_pkt_fmt dsi_pkt_fmt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .byte_ready(byte_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_is_hdr(out_is_hdr), .err_reject(err_reject)
);

// File: tb/dsi_pkt_fmt_bench.sv
`timescale 1ns/1ps
module dsi_pkt_fmt_bench;
   localparam int LEN_W = 16;
   localparam int CAP   = 8;
   localparam int NVEC  = 10;
   // {auto, dtype, vc, len, expected dtype}
   localparam logic [22:0] VEC [0:NVEC-1] = '{
      {1'b0, 6'h05, 2'd0, 8'd1, 6'h05},
      {1'b0, 6'h15, 2'd1, 8'd2, 6'h15},
      {1'b0, 6'h39, 2'd2, 8'd7, 6'h39},
      {1'b0, 6'h29, 2'd3, 8'd8, 6'h29},
      {1'b0, 6'h08, 2'd1, 8'd2, 6'h08},
      {1'b0, 6'h09, 2'd0, 8'd3, 6'h09},
      {1'b0, 6'h19, 2'd2, 8'd1, 6'h19},
      {1'b1, 6'h00, 2'd0, 8'd1, 6'h05},
      {1'b1, 6'h00, 2'd1, 8'd2, 6'h15},
      {1'b1, 6'h3F, 2'd3, 8'd5, 6'h39}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_auto_dcs = 1'b0;
   logic [5:0] req_dtype = '0;
   logic [1:0] req_vc = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic byte_valid = 1'b0, out_ready = 1'b1;
   logic [7:0] byte_data = '0;
   logic req_ready, byte_ready, out_valid, out_is_hdr, err_reject, warn_oversize;
   logic [31:0] out_data;

   int tests = 0, fails = 0, ncap = 0, cyc = 0;
   logic [31:0] cap_d [0:15];
   logic        cap_h [0:15];

   always #5 clk = ~clk;

   dsi_pkt_fmt #(.LEN_W(LEN_W), .FIFO_BYTES(CAP), .AUTO_DCS(1'b1)) u_dsi_pkt_fmt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_dtype(req_dtype), .req_vc(req_vc), .req_len(req_len),
      .req_auto_dcs(req_auto_dcs), .byte_valid(byte_valid), .byte_ready(byte_ready),
      .byte_data(byte_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_is_hdr(out_is_hdr), .err_reject(err_reject),
      .warn_oversize(warn_oversize)
   );

   always @(negedge clk) if (rst_n && out_valid && out_ready && ncap < 16) begin
      cap_d[ncap] = out_data;
      cap_h[ncap] = out_is_hdr;
      ncap = ncap + 1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int base, input int i);
      return 8'(base * 29 + i * 37 + 1);
   endfunction

   task automatic issue(input bit au, input logic [5:0] dt, input logic [1:0] vc, input int len);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_auto_dcs = au; req_dtype = dt; req_vc = vc; req_len = LEN_W'(len);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic run_pkt(input bit au, input logic [5:0] dt, input logic [1:0] vc,
                          input int len, input logic [5:0] exp_dt, input int base);
      logic [31:0] ew [0:15];
      int ne = 0;
      bit sh;
      logic [31:0] w;
      sh = exp_dt[3:0] < 4'd9;
      ncap = 0;
      issue(au, dt, vc, len);
      for (int i = 0; i < len; i++) begin
         byte_valid = 1'b1; byte_data = bval(base, i);
         @(negedge clk);
         if (i == 0) begin
            chk(err_reject == 1'b0, "R3 no false reject", 32'(err_reject), 0);
            chk(warn_oversize == (len > CAP), "R9 oversize flag", 32'(warn_oversize), 32'(len > CAP));
         end
         while (!byte_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      byte_valid = 1'b0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (!sh) begin
         for (int wi = 0; wi < (len + 3) / 4; wi++) begin
            w = '0;
            for (int k = 0; k < 4; k++) if (wi * 4 + k < len) w[k*8 +: 8] = bval(base, wi * 4 + k);
            ew[ne] = w; ne++;
         end
         ew[ne] = {8'h00, 8'(len >> 8), 8'(len), vc, exp_dt};
      end else begin
         ew[ne] = {8'h00, (len == 2) ? bval(base, 1) : 8'h00, bval(base, 0), vc, exp_dt};
      end
      ne++;
      chk(ncap == ne, au ? "R8 R2 word count" : "R2 word count", 32'(ncap), 32'(ne));
      for (int j = 0; j < ne && j < ncap; j++) begin
         if (j == ne - 1) begin
            chk(cap_h[j] == 1'b1, "R7 header tag last", 32'(cap_h[j]), 1);
            chk(cap_d[j] == ew[j], au ? "R8 R1 header" : (sh ? "R4 R1 header" : "R5 R1 header"),
                cap_d[j], ew[j]);
         end else begin
            chk(cap_h[j] == 1'b0, "R7 payload tag", 32'(cap_h[j]), 0);
            chk(cap_d[j] == ew[j], "R6 payload word", cap_d[j], ew[j]);
         end
      end
   endtask

   task automatic try_reject(input logic [5:0] dt, input int len);
      ncap = 0;
      issue(1'b0, dt, 2'd1, len);
      @(negedge clk);
      chk(err_reject == 1'b1, "R3 reject flag", 32'(err_reject), 1);
      chk(req_ready == 1'b1 && byte_ready == 1'b0, "R3 stays idle", {30'd0, req_ready, byte_ready}, 32'h2);
      repeat (3) @(negedge clk);
      chk(ncap == 0 && err_reject == 1'b0, "R3 no output", 32'(ncap), 0);
   endtask

   initial begin
      logic [31:0] held;
      repeat (2) @(negedge clk);
      chk(req_ready && !out_valid && !byte_ready && !err_reject && !warn_oversize,
          "R11 reset state", {27'd0, req_ready, out_valid, byte_ready, err_reject, warn_oversize}, 32'h10);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < NVEC; v++)
         run_pkt(VEC[v][22], VEC[v][21:16], VEC[v][15:14], int'(VEC[v][13:6]), VEC[v][5:0], v);
      // R3 rejects
      try_reject(6'h05, 0);
      try_reject(6'h15, 3);
      try_reject(6'h39, 0);
      // R9 oversize, still emitted
      run_pkt(1'b0, 6'h39, 2'd0, 10, 6'h39, 20);
      // R10 stall hold
      ncap = 0;
      #1 out_ready = 1'b0;
      issue(1'b0, 6'h39, 2'd1, 4);
      for (int i = 0; i < 4; i++) begin
         byte_valid = 1'b1; byte_data = bval(30, i);
         @(negedge clk);
         while (!byte_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      byte_valid = 1'b0;
      @(negedge clk);
      held = out_data;
      chk(out_valid && !req_ready, "R10 stalled offer", {30'd0, out_valid, req_ready}, 32'h2);
      repeat (4) @(negedge clk);
      chk(out_data == held && out_valid && !out_is_hdr, "R10 word held", out_data, held);
      chk(!req_ready, "R10 no new request", 32'(req_ready), 0);
      @(posedge clk); #1 out_ready = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      chk(ncap == 2 && cap_d[0] == held && cap_d[1] == {8'h00, 8'h00, 8'h04, 2'd1, 6'h39},
          "R10 drain after stall", cap_d[1], {8'h00, 8'h00, 8'h04, 2'd1, 6'h39});
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule